// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor datapath that completes one instruction on every clock edge. It holds the program counter, a 32-entry register file, the ALU, sign extension, the next-address logic for branches and jumps, and the selectors that route operands and write-back data. The instruction memory and the data memory are separate and sit outside the block. The instruction is fetched at the program counter. The data memory is read combinationally and written on the clock edge.

The main control decoder is a separate block. The core presents the 6-bit opcode field on `op_field` and takes the decoded control lines back as inputs. Those lines select the destination register field, the second ALU operand and the write-back source. They also enable the register and memory writes, mark branches and jumps, and give a 2-bit ALU class. The core decodes the ALU class itself, using the function field for register-register instructions.

The supported instructions are word load, word store, add, subtract, OR, signed set-less-than, branch-if-equal and absolute jump.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 (`imem_addr` = 0), and `dmem_we` stays low for as long as `rst` is high.
- R2: Outside reset, the next `imem_addr` is the current one plus 4 unless a branch is taken or a jump executes. This applies to loads, stores, register-register instructions and branches that are not taken.
- R3: Register-register instructions (`alu_class` = 2'b10) take rs from bits 25:21, rt from bits 20:16 and rd from bits 15:11. They write rd with the result chosen by the function field in bits 5:0: 0x20 add, 0x22 subtract, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R4: A load writes register rt with the data word at address rs + sign-extended bits 15:0. A negative offset must give a lower address.
- R5: A store drives `dmem_addr` = rs + sign-extended offset and `dmem_wdata` = rt, with `dmem_we` high. It writes no register.
- R6: A branch (`alu_class` = 2'b01, `ctl_branch` high) subtracts rt from rs. When the result is zero, the next address is PC+4 plus the sign-extended offset shifted left by 2. Otherwise it is PC+4.
- R7: A jump sets the next address to bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: A register written by one instruction holds the new value for the next instruction. A register read in the same cycle as its write returns the old value, without a race.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_we | output | 1 | Data memory write enable, applied on the clock edge |
| dmem_rdata | input | 32 | Data memory read word at `dmem_addr` |
| op_field | output | 6 | Opcode bits 31:26 for the external decoder |
| ctl_reg_dst | input | 1 | 1: destination is rd, 0: destination is rt |
| ctl_alu_src | input | 1 | 1: second ALU operand is the sign-extended immediate |
| ctl_mem_to_reg | input | 1 | 1: write-back comes from the data memory |
| ctl_reg_write | input | 1 | Register file write enable |
| ctl_mem_write | input | 1 | Store enable |
| ctl_branch | input | 1 | Instruction is a branch-if-equal |
| ctl_jump | input | 1 | Instruction is an absolute jump |
| alu_class | input | 2 | 00 add, 01 subtract, 10 decode the function field |

## Verification
The next address and all `dmem_*` outputs are combinational from the current instruction, so they are due in the same cycle. Register and memory writes, and program-counter updates, take effect at the next rising edge. The bench drives and releases reset on falling edges, counts whole cycles, and reads memories and `imem_addr` only on falling edges. Each result is therefore checked a full edge after the instruction that produced it. A program of fifteen instructions runs for every pair from a set of corner operands. It finishes in a jump loop, so the stored results and the final address are stable when they are compared.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic [5:0]  op_field,
  input  logic        ctl_reg_dst,
  input  logic        ctl_alu_src,
  input  logic        ctl_mem_to_reg,
  input  logic        ctl_reg_write,
  input  logic        ctl_mem_write,
  input  logic        ctl_branch,
  input  logic        ctl_jump,
  input  logic [1:0]  alu_class
);

  logic [31:0] pc, pc_plus4, pc_next, br_target, jmp_target;
  logic [31:0] regs [32];
  logic [4:0]  rs, rt, rd, dst;
  logic [31:0] rs_val, rt_val, simm, opb, alu_y, wb_val;
  logic        alu_zero;

  assign imem_addr = pc;
  assign op_field  = imem_rdata[31:26];
  assign rs        = imem_rdata[25:21];
  assign rt        = imem_rdata[20:16];
  assign rd        = imem_rdata[15:11];
  assign simm      = {{16{imem_rdata[15]}}, imem_rdata[15:0]};

  assign rs_val = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : regs[rt];
  assign opb    = ctl_alu_src ? simm : rt_val;

  always_comb begin
    unique case (alu_class)
      2'b00:   alu_y = rs_val + opb;
      2'b01:   alu_y = rs_val - opb;
      default: begin
        case (imem_rdata[5:0])
          6'h22:   alu_y = rs_val - opb;
          6'h25:   alu_y = rs_val | opb;
          6'h2A:   alu_y = {31'd0, $signed(rs_val) < $signed(opb)};
          default: alu_y = rs_val + opb;
        endcase
      end
    endcase
  end

  assign alu_zero = (alu_y == 32'd0);

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl_mem_write & ~rst;

  assign wb_val = ctl_mem_to_reg ? dmem_rdata : alu_y;
  assign dst    = ctl_reg_dst ? rd : rt;

  always_ff @(posedge clk) begin
    if (!rst && ctl_reg_write && dst != 5'd0)
      regs[dst] <= wb_val;
  end

  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {simm[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};

  always_comb begin
    if (ctl_jump)                     pc_next = jmp_target;
    else if (ctl_branch && alu_zero)  pc_next = br_target;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic        ctl_branch,
  input logic        ctl_jump,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);

  logic [31:0] exp_br, exp_jmp, exp_seq;
  assign exp_seq = imem_addr + 32'd4;
  assign exp_br  = exp_seq + {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
  assign exp_jmp = {exp_seq[31:28], imem_rdata[25:0], 2'b00};

  AST_RESET_PC: assert property (@(posedge clk) rst |=> imem_addr == 32'd0); // R1

  always @(posedge clk) begin
    if (rst) AST_NO_STORE_IN_RESET: assert (!dmem_we); // R1
  end

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!ctl_jump && !ctl_branch) |=> imem_addr == $past(exp_seq)); // R2

  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!ctl_jump && ctl_branch && rs_val == rt_val) |=> imem_addr == $past(exp_br)); // R6

  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!ctl_jump && ctl_branch && rs_val != rt_val) |=> imem_addr == $past(exp_seq)); // R6

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctl_jump |=> imem_addr == $past(exp_jmp)); // R7

endmodule

bind sc_core sc_core_chk chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_we(dmem_we), .ctl_branch(ctl_branch), .ctl_jump(ctl_jump),
  .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [5:0]  op_field;
  logic        c_dst, c_src, c_m2r, c_rw, c_mw, c_br, c_j;
  logic [1:0]  c_alu;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .op_field(op_field),
    .ctl_reg_dst(c_dst), .ctl_alu_src(c_src), .ctl_mem_to_reg(c_m2r),
    .ctl_reg_write(c_rw), .ctl_mem_write(c_mw), .ctl_branch(c_br),
    .ctl_jump(c_j), .alu_class(c_alu)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // external decoder model: opcodes 0x00 reg-reg, 0x23 load, 0x2B store, 0x04 branch, 0x02 jump
  always_comb begin
    {c_dst, c_src, c_m2r, c_rw, c_mw, c_br, c_j} = '0;
    c_alu = 2'b00;
    case (op_field)
      6'h00: begin c_dst = 1; c_rw = 1; c_alu = 2'b10; end
      6'h23: begin c_src = 1; c_m2r = 1; c_rw = 1; end
      6'h2B: begin c_src = 1; c_mw = 1; end
      6'h04: begin c_br = 1; c_alu = 2'b01; end
      6'h02: c_j = 1;
      default: ;
    endcase
  end

  function automatic logic [31:0] rr(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] jj(input int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = jj(i);
      dmem[i] = 32'h0;
    end
  endtask

  localparam logic [31:0] SENT = 32'hDEADBEEF;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] vals [8];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h8000_0000, 32'h5, 32'hFFFF_FFFB, 32'h1234_5678};

    // R1: reset holds PC at 0 and suppresses a store sitting at address 0
    clear_mem();
    imem[0] = ii(6'h2B, 0, 0, 0);
    dmem[0] = SENT;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'd0);
    check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    check("R1 memory untouched", dmem[0], SENT);

    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        logic [31:0] a, b;
        a = vals[ia];
        b = vals[ib];
        rst = 1'b1;
        @(negedge clk);
        clear_mem();
        imem[0]  = ii(6'h23, 0, 1, 0);
        imem[1]  = ii(6'h23, 0, 2, 4);
        imem[2]  = rr(1, 2, 3, 6'h20);
        imem[3]  = rr(1, 2, 4, 6'h22);
        imem[4]  = rr(1, 2, 5, 6'h25);
        imem[5]  = rr(1, 2, 6, 6'h2A);
        imem[6]  = rr(1, 2, 0, 6'h20);
        imem[7]  = ii(6'h2B, 0, 3, 8);
        imem[8]  = ii(6'h2B, 0, 4, 12);
        imem[9]  = ii(6'h2B, 0, 5, 16);
        imem[10] = ii(6'h2B, 0, 6, 20);
        imem[11] = ii(6'h2B, 0, 0, 28);
        imem[12] = ii(6'h04, 1, 2, 1);
        imem[13] = ii(6'h2B, 0, 1, 24);
        imem[14] = jj(14);
        dmem[0] = a;
        dmem[1] = b;
        dmem[6] = SENT;
        dmem[7] = 32'hFFFF_FFFF;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 sequential pc", imem_addr, 32'd12);
        repeat (14) @(negedge clk);
        check("R3 add", dmem[2], a + b);
        check("R3 sub", dmem[3], a - b);
        check("R3 or", dmem[4], a | b);
        check("R3 slt", dmem[5], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R8 r0 reads zero", dmem[7], 32'd0);
        check("R6 beq forward", dmem[6], (a == b) ? SENT : a);
        check("R7 jump target", imem_addr, 32'd56);
        check("R4 R9 load then use", dmem[0], a);
        check("R5 store writes no register", dmem[1], b);
      end
    end

    // R4/R5 negative offset, R6 backward and not-taken branches
    rst = 1'b1;
    @(negedge clk);
    clear_mem();
    imem[0] = ii(6'h23, 0, 1, 0);
    imem[1] = ii(6'h2B, 1, 1, -8);
    imem[2] = ii(6'h04, 1, 0, 5);
    imem[3] = ii(6'h04, 0, 0, -1);
    dmem[0] = 32'd40;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 not-taken branch", imem_addr, 32'd12);
    repeat (6) @(negedge clk);
    check("R5 negative offset store", dmem[8], 32'd40);
    check("R6 backward self branch", imem_addr, 32'd12);

    // R7 jump keeps upper PC bits of PC+4 (zero here) and lands on word 40
    rst = 1'b1;
    @(negedge clk);
    clear_mem();
    imem[0] = jj(40);
    imem[40] = ii(6'h2B, 0, 0, 4);
    dmem[1] = SENT;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 jump to word 40", imem_addr, 32'd160);
    @(negedge clk);
    check("R5 store after jump", dmem[1], 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule